// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block is a memory-mapped watchdog for a management controller. It holds a 16-bit down-counter that loses one count per tick. A tick is one watchdog period, nominally 128 ms. A prescaler derives the tick from the core clock. Software reaches the block through a small register bus with three locations: a status byte, the timer halfword and a control byte.

To arm the watchdog, software writes the reload value to the timer location and then sets the enable bit in the control byte. It can also set the pre-timeout bit in the same control write. To keep the system alive, software rewrites the timer location before the count runs out. Reading the timer location returns the ticks still left. Clearing the enable bit freezes the count.

If the pre-timeout bit is set, a non-maskable interrupt request goes up when the count falls to a fixed threshold. That threshold is 70 ticks, or 9 s rounded down to whole ticks. The request stays up until software clears it. When the count reaches zero while enabled, the block drives a system reset pulse of fixed length. It then drops the enable bit.

Top module: `wdt_pretimeout`

## Requirements
- R1: After reset the control byte (offset 0x72) reads 0x00, the timer (offset 0x70) reads 0xFFFF, the status byte (offset 0x6E) reads 0x00, and nmi_req and sys_rst are low.
- R2: While control bit 0 is set, the count read at offset 0x70 decreases by one every TICK_CYCLES clocks. The first decrement comes TICK_CYCLES clocks after the write that sets bit 0.
- R3: When the count is zero and control bit 0 is set, sys_rst goes high one clock later and stays high for exactly RST_CYCLES clocks. For a reload value R armed by a control write, the first high cycle is R*TICK_CYCLES+1 clocks after that write.
- R4: When the reset pulse ends, control bit 0 reads 0 and the other seven control bits keep their values.
- R5: A write to offset 0x70 loads the count and restarts the prescaler. A refresh of value R while running therefore delays the reset to R*TICK_CYCLES+1 clocks after the refresh.
- R6: Writing the control byte with bit 0 clear freezes the count and produces no reset. The other written bits read back unchanged.
- R7: With control bit 2 set, a tick that brings the count down to 70 sets status bit 1 (value 0x02 at offset 0x6E). nmi_req then goes high on the same clock. For a reload R greater than 70, this happens (R-70)*TICK_CYCLES clocks after the arming write.
- R8: No pre-timeout is raised when control bit 2 is clear, or when the reload value is 70 or less.
- R9: Writing 1 to status bit 1 clears it and drops nmi_req. Writing 0 there has no effect.
- R10: The control byte reads back all eight bits last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| nmi_req | output | 1 | Pre-timeout interrupt request, follows status bit 1 |
| sys_rst | output | 1 | System reset pulse at expiry |

## Verification
The expiry path is swept over several small reload values. Each sweep measures the clock count to the first reset cycle and the pulse length, which distinguishes an off-by-one in the prescaler from one in the expiry detect. The pre-timeout path is swept over reloads just below, at and just above the 70-tick threshold, plus one well above it. This separates firing on a tick from firing on a reload, and confirms the interrupt enable gates it. Live readback, a mid-run refresh and a stop followed by a long wait check that only timer writes move the count upward and that a stopped counter holds.

// File: rtl/wdt_pretimeout.sv
module wdt_pretimeout #(
  parameter int TICK_CYCLES = 3200000,
  parameter int CNT_W       = 16,
  parameter int PRE_TICKS   = 70,
  parameter int RST_CYCLES  = 16,
  parameter logic [7:0] STAT_ADDR  = 8'h6E,
  parameter logic [7:0] TIMER_ADDR = 8'h70,
  parameter logic [7:0] CTRL_ADDR  = 8'h72
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        nmi_req,
  output logic        sys_rst
);
  localparam int PS_W = $clog2(TICK_CYCLES + 1);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctrl;
  logic             stat;
  logic [PS_W-1:0]  ps;
  logic [RC_W-1:0]  rcnt;

  wire tmr_wr = bus_wr && (bus_addr == TIMER_ADDR);
  wire ctl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  wire st_wr  = bus_wr && (bus_addr == STAT_ADDR);
  wire en     = ctrl[0];
  wire tick   = en && (ps == PS_W'(TICK_CYCLES - 1));
  wire expire = en && (cnt == '0) && (rcnt == '0);
  wire pre_hit = tick && ctrl[2] && (cnt == CNT_W'(PRE_TICKS + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps <= '0;
    else if (!en || tmr_wr || tick) ps <= '0;
    else ps <= ps + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '1;
    else if (tmr_wr) cnt <= bus_wdata[CNT_W-1:0];
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= 1'b0;
    else if (pre_hit) stat <= 1'b1;
    else if (st_wr && bus_wdata[1]) stat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctl_wr) ctrl <= bus_wdata[7:0];
      if (rcnt == RC_W'(1)) ctrl[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcnt <= '0;
    else if (expire) rcnt <= RC_W'(RST_CYCLES);
    else if (rcnt != '0) rcnt <= rcnt - 1'b1;
  end

  assign sys_rst = (rcnt != '0);
  assign nmi_req = stat;

  always_comb begin
    case (bus_addr)
      TIMER_ADDR: bus_rdata = 16'(cnt);
      CTRL_ADDR:  bus_rdata = {8'h00, ctrl};
      STAT_ADDR:  bus_rdata = {14'h0, stat, 1'b0};
      default:    bus_rdata = 16'h0000;
    endcase
  end
endmodule

module wdt_pretimeout_chk #(
  parameter int CNT_W      = 16,
  parameter int PRE_TICKS  = 70,
  parameter int RST_CYCLES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       ctrl,
  input logic             nmi_req,
  input logic             sys_rst
);
  localparam int HI_W = $clog2(RST_CYCLES + 2);
  logic [HI_W-1:0] hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi <= '0;
    else if (!sys_rst) hi <= '0;
    else hi <= hi + 1'b1;
  end

  p_no_climb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> cnt <= $past(cnt));
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !tmr_wr) |=> $stable(cnt));
  p_nmi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> (cnt == CNT_W'(PRE_TICKS)) && $past(ctrl[2]));
  p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> hi < HI_W'(RST_CYCLES));
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> hi == HI_W'(RST_CYCLES));
  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> !ctrl[0]);
endmodule

bind wdt_pretimeout wdt_pretimeout_chk #(
  .CNT_W(CNT_W), .PRE_TICKS(PRE_TICKS), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .cnt(cnt),
  .ctrl(ctrl), .nmi_req(nmi_req), .sys_rst(sys_rst)
);

// File: tb/sim_wdt_pretimeout.sv
`timescale 1ns/1ps
module sim_wdt_pretimeout;
  localparam int T = 4;
  localparam int PRE = 70;
  localparam int RL = 16;
  localparam logic [7:0] A_ST = 8'h6E, A_TM = 8'h70, A_CT = 8'h72;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic nmi_req, sys_rst;
  int checks = 0, fails = 0;

  wdt_pretimeout #(.TICK_CYCLES(T)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_req(nmi_req), .sys_rst(sys_rst));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a; #0.5 v = int'(bus_rdata);
  endtask

  task automatic measure(input int limit, output int n_nmi, output int n_rst, output int len);
    n_nmi = -1; n_rst = -1; len = 0;
    for (int n = 1; n <= limit; n++) begin
      @(posedge clk); #1;
      if (nmi_req && n_nmi < 0) n_nmi = n;
      if (sys_rst) begin
        if (n_rst < 0) n_rst = n;
        len++;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v, nn, nr, ln;
    int rs[5] = '{1, 2, 3, 5, 8};
    int ps[5] = '{69, 70, 71, 72, 90};
    #12 rst_n = 1;
    @(posedge clk); #1;
    rd(A_CT, v); chk("R1 ctrl", v, 0);
    rd(A_TM, v); chk("R1 timer", v, 16'hFFFF);
    rd(A_ST, v); chk("R1 status", v, 0);
    chk("R1 nmi", int'(nmi_req), 0);
    chk("R1 rst", int'(sys_rst), 0);

    wr(A_CT, 16'h00A4); rd(A_CT, v); chk("R10 readback", v, 8'hA4);
    wr(A_CT, 16'h0000);

    foreach (rs[i]) begin
      wr(A_TM, 16'(rs[i])); wr(A_CT, 16'h0081);
      measure(rs[i] * T + 30, nn, nr, ln);
      chk("R3 first reset cycle", nr, rs[i] * T + 1);
      chk("R3 pulse length", ln, RL);
      chk("R8 no nmi without bit2", nn, -1);
      rd(A_CT, v); chk("R4 enable dropped", v, 8'h80);
    end

    foreach (ps[i]) begin
      wr(A_TM, 16'(ps[i])); wr(A_CT, 16'h0085);
      measure(ps[i] * T + 30, nn, nr, ln);
      chk(ps[i] > PRE ? "R7 nmi time" : "R8 no nmi at low reload", nn,
          ps[i] > PRE ? (ps[i] - PRE) * T : -1);
      chk("R3 reset time with pre", nr, ps[i] * T + 1);
      rd(A_CT, v); chk("R4 bits kept", v, 8'h84);
      rd(A_ST, v); chk("R7 status bit", v, ps[i] > PRE ? 2 : 0);
      wr(A_ST, 16'h0000); chk("R9 write 0 keeps", int'(nmi_req), ps[i] > PRE ? 1 : 0);
      wr(A_ST, 16'h0002); chk("R9 clear", int'(nmi_req), 0);
      rd(A_ST, v); chk("R9 status cleared", v, 0);
    end

    wr(A_TM, 16'd75); wr(A_CT, 16'h0081);
    measure(75 * T + 30, nn, nr, ln);
    chk("R8 no nmi bit2 clear", nn, -1);

    wr(A_TM, 16'd20); wr(A_CT, 16'h0081);
    for (int n = 1; n <= 24; n++) begin
      @(posedge clk); #1; rd(A_TM, v);
      chk("R2 live count", v, 20 - n / T);
    end
    wr(A_CT, 16'h0000);

    wr(A_TM, 16'd30); wr(A_CT, 16'h0085);
    repeat (10) @(posedge clk);
    wr(A_CT, 16'h0004);
    #1 rd(A_TM, v); chk("R6 frozen value", v, 28);
    measure(50, nn, nr, ln);
    rd(A_TM, v); chk("R6 still frozen", v, 28);
    chk("R6 no reset", nr, -1);
    rd(A_CT, v); chk("R6 bits kept", v, 8'h04);

    wr(A_TM, 16'd50); wr(A_CT, 16'h0081);
    repeat (30) @(posedge clk);
    wr(A_TM, 16'd10);
    measure(10 * T + 30, nn, nr, ln);
    chk("R5 refresh reset time", nr, 10 * T + 1);
    chk("R5 pulse length", ln, RL);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule